// File: doc/BRIEF.md
# Loop Code Detector

This block watches a received serial bit stream for the two in-band loopback codes carried on a line. Each valid bit is marked by a one-clock enable. The loop-up code is the five-bit figure 0,0,0,0,1 repeated without a break. The loop-down code is the three-bit figure 0,0,1 repeated the same way. The detector finds either code at any bit alignment. It needs no framing and no knowledge of where a repetition starts.

A code is declared only after it has held, without a single wrong bit, for a programmable number of bit times. The default is 74112 bit times, which is 48 ms at 1.544 Mb/s. Each code has its own level flag. The flag stays high while the code continues and drops on the first bit that breaks it. A rise of either flag produces a one-clock event pulse. A mask input gates that pulse, and the system uses the pulse as an interrupt request. The loopback action itself is left to the surrounding logic.

Top module: `loop_code_detector`

## Requirements
- R1: A stream in which 0,0,0,0,1 (in time order) repeats, entered at any of the five phases, is recognised as the loop-up code.
- R2: A stream in which 0,0,1 (in time order) repeats, entered at any of the three phases, is recognised as the loop-down code.
- R3: An accepted bit counts as matching for a code of length P when it and the P-1 bits accepted before it since reset form a rotation of that code. The code's flag goes high on the clock edge that accepts the PERSIST-th consecutive matching bit, and not one bit earlier.
- R4: A non-matching accepted bit clears that code's run count and its flag on the same edge.
- R5: Clock cycles with the bit enable low change neither flag, and they produce no event.
- R6: The event output is high for exactly one clock, on the edge where either flag rises, provided the mask input is 1 on that edge.
- R7: When the mask input is 0 on the edge where a flag rises, the flag still rises and no event is produced.
- R8: A synchronous reset clears both flags, the event, both run counts and the bit history. After reset a code of length P cannot match until P fresh bits have been accepted.
- R9: The loop-up flag and the loop-down flag are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | One-clock strobe marking a valid received bit |
| rxBit | input | 1 | Received bit, sampled when bitEn is high |
| irqMask | input | 1 | 1 lets a detection raise the event, 0 suppresses it |
| loopUpDet | output | 1 | Loop-up code detected and still present |
| loopDownDet | output | 1 | Loop-down code detected and still present |
| codeEvent | output | 1 | One-clock pulse when either detected flag rises |

## Verification
The bench builds the detector with a persistence of 20 bit times and keeps the default code patterns. With that setting a declaration, its boundary at 19 versus 20 matching bits, and the clear after a violation all fall within a few dozen bits. A long random run can therefore cross many detections and drops of both codes, direct switches between the codes, and masked and unmasked rises. The default of 74112 shares the same counter logic and only widens it.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  // Strobes issued by the control to the datapath for one accepted bit
  typedef struct packed {
    logic shiftEn;
    logic incUp;
    logic clrUp;
    logic incDown;
    logic clrDown;
  } lcdStrobe_t;

endpackage

// File: rtl/lcd_rot_match.sv
module lcd_rot_match #(
  parameter int             LEN     = 5,
  parameter logic [LEN-1:0] PATTERN = 5'b00001
) (
  input  logic [LEN-1:0] win,
  input  logic           valid,
  output logic           hit
);

  // One comparator per rotation of the pattern
  logic [LEN-1:0] rotHit;

  generate
    for (genvar r = 0; r < LEN; r++) begin : g_rot
      assign rotHit[r] = (win == ((PATTERN << r) | (PATTERN >> (LEN - r))));
    end
  endgenerate

  assign hit = valid && (|rotHit);

endmodule

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int                  UP_LEN       = 5,
  parameter int                  DOWN_LEN     = 3,
  parameter logic [UP_LEN-1:0]   UP_PATTERN   = 5'b00001,
  parameter logic [DOWN_LEN-1:0] DOWN_PATTERN = 3'b001,
  parameter int                  PERSIST      = 74112
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxBit,
  input  lcdStrobe_t strobe,
  output logic       matchUp,
  output logic       matchDown,
  output logic       upFull,
  output logic       downFull
);

  localparam int HIST_LEN = (UP_LEN > DOWN_LEN) ? UP_LEN : DOWN_LEN;
  localparam int FILL_W   = $clog2(HIST_LEN);
  localparam int CNT_W    = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(PERSIST - 1);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(HIST_LEN - 1);

  // Bit history, newest at bit 0; window includes the incoming bit
  logic [HIST_LEN-2:0] hist;
  logic [HIST_LEN-1:0] nextWin;
  logic [FILL_W-1:0]   fill;
  logic                upValid;
  logic                downValid;

  assign nextWin   = {hist, rxBit};
  assign upValid   = (fill >= FILL_W'(UP_LEN - 1));
  assign downValid = (fill >= FILL_W'(DOWN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      fill <= '0;
    end else if (strobe.shiftEn) begin
      hist <= nextWin[HIST_LEN-2:0];
      if (fill != FILL_TOP) fill <= fill + 1'b1;
    end
  end

  lcd_rot_match #(.LEN(UP_LEN), .PATTERN(UP_PATTERN)) u_upMatch (
    .win   (nextWin[UP_LEN-1:0]),
    .valid (upValid),
    .hit   (matchUp)
  );

  lcd_rot_match #(.LEN(DOWN_LEN), .PATTERN(DOWN_PATTERN)) u_downMatch (
    .win   (nextWin[DOWN_LEN-1:0]),
    .valid (downValid),
    .hit   (matchDown)
  );

  // Persistence counters: index 0 loop-up, index 1 loop-down
  logic [1:0]       incV;
  logic [1:0]       clrV;
  logic [1:0]       fullV;
  logic [CNT_W-1:0] runCnt [2];

  assign incV = {strobe.incDown, strobe.incUp};
  assign clrV = {strobe.clrDown, strobe.clrUp};

  generate
    for (genvar k = 0; k < 2; k++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)                              runCnt[k] <= '0;
        else if (clrV[k])                     runCnt[k] <= '0;
        else if (incV[k] && runCnt[k] != CNT_TOP) runCnt[k] <= runCnt[k] + 1'b1;
      end
      assign fullV[k] = (runCnt[k] == CNT_TOP);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        runCnt[k] <= CNT_TOP);                                      // R3
      AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clrV[k] |=> runCnt[k] == '0);                               // R4
    end
  endgenerate

  assign upFull   = fullV[0];
  assign downFull = fullV[1];

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(fill) && $stable(hist));            // R5

endmodule

// File: rtl/lcd_control.sv
module lcd_control
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bitEn,
  input  logic       irqMask,
  input  logic       matchUp,
  input  logic       matchDown,
  input  logic       upFull,
  input  logic       downFull,
  output lcdStrobe_t strobe,
  output logic       upStat,
  output logic       downStat,
  output logic       codeEvent
);

  logic upHitNow;
  logic downHitNow;

  assign upHitNow   = matchUp && upFull;
  assign downHitNow = matchDown && downFull;

  always_comb begin
    strobe.shiftEn = bitEn;
    strobe.incUp   = bitEn && matchUp;
    strobe.clrUp   = bitEn && !matchUp;
    strobe.incDown = bitEn && matchDown;
    strobe.clrDown = bitEn && !matchDown;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upStat    <= 1'b0;
      downStat  <= 1'b0;
      codeEvent <= 1'b0;
    end else if (bitEn) begin
      upStat    <= upHitNow;
      downStat  <= downHitNow;
      codeEvent <= irqMask && ((upHitNow && !upStat) || (downHitNow && !downStat));
    end else begin
      codeEvent <= 1'b0;
    end
  end

  AST_UP_DROPS: assert property (@(posedge clk) disable iff (rst)
    bitEn && !matchUp |=> !upStat);                                 // R4
  AST_DOWN_DROPS: assert property (@(posedge clk) disable iff (rst)
    bitEn && !matchDown |=> !downStat);                             // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable(upStat) && $stable(downStat) && !codeEvent); // R5
  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    codeEvent |=> !codeEvent);                                      // R6
  AST_EVENT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    codeEvent |-> (upStat && !$past(upStat)) || (downStat && !$past(downStat))); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !irqMask |=> !codeEvent);                                       // R7
  AST_CODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(upStat && downStat));                                         // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !upStat && !downStat && !codeEvent);                    // R8

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector #(
  parameter int UP_LEN       = 5,
  parameter int DOWN_LEN     = 3,
  parameter logic [UP_LEN-1:0]   UP_PATTERN   = 5'b00001,
  parameter logic [DOWN_LEN-1:0] DOWN_PATTERN = 3'b001,
  parameter int PERSIST      = 74112
) (
  input  logic clk,
  input  logic rst,
  input  logic bitEn,
  input  logic rxBit,
  input  logic irqMask,
  output logic loopUpDet,
  output logic loopDownDet,
  output logic codeEvent
);

  lcd_pkg::lcdStrobe_t strobe;
  logic matchUp;
  logic matchDown;
  logic upFull;
  logic downFull;

  lcd_datapath #(
    .UP_LEN       (UP_LEN),
    .DOWN_LEN     (DOWN_LEN),
    .UP_PATTERN   (UP_PATTERN),
    .DOWN_PATTERN (DOWN_PATTERN),
    .PERSIST      (PERSIST)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .rxBit     (rxBit),
    .strobe    (strobe),
    .matchUp   (matchUp),
    .matchDown (matchDown),
    .upFull    (upFull),
    .downFull  (downFull)
  );

  lcd_control u_control (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .irqMask   (irqMask),
    .matchUp   (matchUp),
    .matchDown (matchDown),
    .upFull    (upFull),
    .downFull  (downFull),
    .strobe    (strobe),
    .upStat    (loopUpDet),
    .downStat  (loopDownDet),
    .codeEvent (codeEvent)
  );

endmodule

// File: tb/loop_code_detector_bench.sv
`timescale 1ns/1ps
module loop_code_detector_bench;

  localparam int PERS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitEn = 1'b0;
  logic rxBit = 1'b0;
  logic irqMask = 1'b0;
  logic loopUpDet;
  logic loopDownDet;
  logic codeEvent;

  always #4 clk = ~clk;

  loop_code_detector #(.PERSIST(PERS)) u_loop_code_detector (
    .clk         (clk),
    .rst         (rst),
    .bitEn       (bitEn),
    .rxBit       (rxBit),
    .irqMask     (irqMask),
    .loopUpDet   (loopUpDet),
    .loopDownDet (loopDownDet),
    .codeEvent   (codeEvent)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state
  logic [7:0] hw;
  int nb, cu, cd;
  logic expUp, expDown, expEv;

  function automatic logic upWinOk(logic [7:0] w, int n);
    return (n >= 5) && ($countones(w[4:0]) == 1);
  endfunction

  function automatic logic downWinOk(logic [7:0] w, int n);
    return (n >= 3) && ($countones(w[2:0]) == 1);
  endfunction

  task automatic check(string tag);
    checks++;
    if ({loopUpDet, loopDownDet, codeEvent} !== {expUp, expDown, expEv}) begin
      fails++;
      $display("FAIL %s: up/down/event actual %b%b%b expected %b%b%b",
               tag, loopUpDet, loopDownDet, codeEvent, expUp, expDown, expEv);
    end
  endtask

  task automatic modelClear();
    hw = '0; nb = 0; cu = 0; cd = 0;
    expUp = 1'b0; expDown = 1'b0; expEv = 1'b0;
  endtask

  task automatic doReset(string tag);
    rst = 1'b1; bitEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelClear();
    check(tag);
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic sendBit(logic b, logic m, string tag);
    logic oldUp, oldDown;
    bitEn = 1'b1; rxBit = b; irqMask = m;
    @(negedge clk);
    hw = {hw[6:0], b};
    if (nb < 8) nb++;
    oldUp = expUp; oldDown = expDown;
    cu = upWinOk(hw, nb)   ? cu + 1 : 0;
    cd = downWinOk(hw, nb) ? cd + 1 : 0;
    expUp   = (cu >= PERS);
    expDown = (cd >= PERS);
    expEv   = m && ((expUp && !oldUp) || (expDown && !oldDown));
    bitEn = 1'b0;
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      bitEn = 1'b0; rxBit = $urandom_range(0, 1); irqMask = 1'b1;
      @(negedge clk);
      expEv = 1'b0;
      check(tag);
    end
  endtask

  task automatic upRun(int n, int phase, logic m, string tag);
    for (int i = 0; i < n; i++) sendBit(((i + phase) % 5) == 4, m, tag);
  endtask

  task automatic downRun(int n, int phase, logic m, string tag);
    for (int i = 0; i < n; i++) sendBit(((i + phase) % 3) == 2, m, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelClear();
    @(negedge clk);
    doReset("R8");

    // Loop-up at each phase, unmasked
    for (int p = 0; p < 5; p++) begin
      doReset("R8");
      upRun(2 * PERS + p, p, 1'b1, "R1");
    end
    upRun(3, 0, 1'b1, "R6");

    // Idle gaps interleaved with the code
    idle(4, "R5");
    for (int i = 0; i < 10; i++) begin
      sendBit((i % 5) == 1, 1'b1, "R5");
      idle(i % 3, "R5");
    end

    // Break a detected loop-up with a wrong bit
    doReset("R8");
    upRun(PERS + 6, 0, 1'b1, "R1");
    sendBit(1'b1, 1'b1, "R4");
    upRun(PERS + 8, 0, 1'b1, "R4");

    // Loop-down at each phase
    for (int p = 0; p < 3; p++) begin
      doReset("R8");
      downRun(PERS + 4 + p, p, 1'b1, "R2");
    end
    sendBit(1'b1, 1'b1, "R4");

    // Boundary: PERS-1 matching bits then a break, then exactly PERS
    doReset("R8");
    upRun(4 + PERS - 1, 0, 1'b1, "R3");
    sendBit(1'b1, 1'b1, "R3");
    upRun(4 + PERS, 1, 1'b1, "R3");

    // Mask off at the rise, then mask on for a fresh rise
    doReset("R8");
    upRun(PERS + 6, 0, 1'b0, "R7");
    downRun(PERS + 5, 0, 1'b1, "R6");

    // Reset in mid detection, then short refill
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    modelClear();
    check("R8");
    upRun(4, 0, 1'b1, "R8");

    // Random segments: codes, noise, switches, mask and idle
    for (int s = 0; s < 400; s++) begin
      int kind, len, ph;
      logic m;
      kind = $urandom_range(0, 3);
      len  = $urandom_range(3, 3 * PERS);
      ph   = $urandom_range(0, 4);
      m    = 1'($urandom_range(0, 1));
      for (int i = 0; i < len; i++) begin
        case (kind)
          0: sendBit(((i + ph) % 5) == 4, m, "R9");
          1: sendBit(((i + ph) % 3) == 2, m, "R9");
          2: sendBit(1'($urandom_range(0, 1)), m, "R9");
          default: sendBit(($urandom_range(0, 15) == 0) ^ (((i + ph) % 5) == 4), m, "R9");
        endcase
        if ($urandom_range(0, 19) == 0) idle(1, "R5");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule